// File: doc/BRIEF.md
# MDIO Management Responder

This block sits on the PHY side of a two-wire management link. It watches the management clock and the shared data line and decodes each serial frame. When a frame carries its own 5-bit station address, it reads or writes one entry of a local bank of thirty-two 16-bit registers. The logic behind those registers is outside the block.

A frame is only accepted after a synchronisation run of at least 32 consecutive ones. Every frame that ends, whether it completes or is dropped part way, clears that run. Each new transaction therefore needs its own run of ones.

On a read, the block lets go of the line for the first turnaround slot and pulls it low for the second. It then shifts the register out, most significant bit first. On a write, it checks the turnaround pattern and stores the 16 received bits. The line is sampled on the rising clock edge, and the block changes its own drive only after a falling edge. The output-enable pin tells the pad when the block owns the line.

Top module: `mdio_responder`

## Requirements
- R1: After reset the line is released (`mdio_oe` low) and every one of the 32 registers reads as 0x0000.
- R2: A frame is decoded only after at least 32 consecutive ones have been sampled. After 31 ones the frame is ignored, with no drive and no register change. A run longer than 32 is accepted.
- R3: After the run of ones, the next two bits must be 0 then 1. Any other pair drops the frame.
- R4: The two operation bits 1,0 select a read and 0,0 select a write. The pairs 0,1 and 1,1 drop the frame.
- R5: The station address and the register address are 5 bits each, sent most significant bit first. When the station address differs from `phy_addr`, the block never drives the line and never changes a register.
- R6: In a matching read, `mdio_oe` is low during the first turnaround bit. During the second turnaround bit, `mdio_oe` is high and `mdio_o` is 0.
- R7: In a matching read, the 16 data bits come out most significant bit first with `mdio_oe` high. The line is released once the last bit has ended. Outside the second turnaround bit and the data bits of a matching read, `mdio_oe` stays low.
- R8: In a matching write, the two turnaround bits must be 1 then 0. The 16 data bits, most significant bit first, are then stored in the addressed register. Any other turnaround pair drops the frame without a write.
- R9: The block samples `mdio_i` on the rising edge of `mdc`. It changes `mdio_o` and `mdio_oe` only on the falling edge, so its output holds steady across each rising edge.
- R10: Once a frame completes or is dropped, the count of ones restarts from zero. A frame that follows with no new run of ones is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock from the station |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_addr | input | 5 | Station address this responder answers to |
| mdio_i | input | 1 | Value seen on the shared data line |
| mdio_o | output | 1 | Value the block drives when enabled |
| mdio_oe | output | 1 | High while the block drives the line |

## Verification
The bench aims at the edges of the synchronisation rule. A run of 31 ones must be refused and a run of 40 accepted. A responder off by one in its counter would answer the short run or refuse the exact one. The bench sends frames with no new run of ones, both after a completed frame and after a dropped frame. A design that kept its count across frames would answer those. Bad delimiter, bad operation code, bad write turnaround and a foreign station address each must leave the register untouched. Reading the register back exposes a design that stored the data anyway. Reads of registers 0x01 and 0x10, holding 0x0001 and 0x8000, catch a reversed bit order in the address or the data. Each driven bit is sampled twice, on both sides of the rising edge. A design that drove the first turnaround slot, or that moved its output on the rising edge, shows a mismatch there.

// File: rtl/mdio_resp_pkg.sv
package mdio_resp_pkg;

    localparam int ADDR_W      = 5;
    localparam int DATA_W      = 16;
    localparam int PRE_LEN_DEF = 32;
    localparam int CNT_W       = 6;
    localparam int IDX_W       = $clog2(DATA_W);

    typedef enum logic [3:0] {
        S_PRE,
        S_ST1,
        S_OP1,
        S_OP2,
        S_PHY,
        S_REG,
        S_TA1,
        S_TA2,
        S_DAT
    } rx_state_e;

    typedef struct packed {
        rx_state_e           st;
        logic [CNT_W-1:0]    cnt;
        logic                op_hi;
        logic                is_rd;
        logic                ta_hi;
        logic [ADDR_W-1:0]   phy;
        logic [ADDR_W-1:0]   ra;
        logic [DATA_W-2:0]   sh;
    } rx_regs_t;

    typedef struct packed {
        logic oe;
        logic o;
    } tx_regs_t;

endpackage

// File: rtl/mdio_rx_fsm.sv
module mdio_rx_fsm
    import mdio_resp_pkg::*;
#(
    parameter int PRE_LEN = PRE_LEN_DEF
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic              mdio_i,
    input  logic [ADDR_W-1:0] phy_cfg,
    output rx_state_e         st,
    output logic [CNT_W-1:0]  cnt,
    output logic              is_rd,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              we,
    output logic [DATA_W-1:0] wdata
);

    localparam logic [CNT_W-1:0] PRE_MAX   = CNT_W'(PRE_LEN);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    rx_regs_t q, d;
    logic     abort;

    always_comb begin
        d     = q;
        abort = 1'b0;
        we    = 1'b0;
        wdata = {q.sh, mdio_i};
        unique case (q.st)
            S_PRE: begin
                if (mdio_i) begin
                    if (q.cnt != PRE_MAX) d.cnt = q.cnt + 1'b1;
                end else if (q.cnt == PRE_MAX) begin
                    d.st  = S_ST1;
                    d.cnt = '0;
                end else begin
                    d.cnt = '0;
                end
            end
            S_ST1: begin
                if (mdio_i) d.st = S_OP1;
                else        abort = 1'b1;
            end
            S_OP1: begin
                d.op_hi = mdio_i;
                d.st    = S_OP2;
            end
            S_OP2: begin
                if (!mdio_i) begin
                    d.is_rd = q.op_hi;
                    d.st    = S_PHY;
                    d.cnt   = '0;
                end else begin
                    abort = 1'b1;
                end
            end
            S_PHY: begin
                d.phy = {q.phy[ADDR_W-2:0], mdio_i};
                if (q.cnt == ADDR_LAST) begin
                    if (d.phy != phy_cfg) begin
                        abort = 1'b1;
                    end else begin
                        d.st  = S_REG;
                        d.cnt = '0;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_REG: begin
                d.ra = {q.ra[ADDR_W-2:0], mdio_i};
                if (q.cnt == ADDR_LAST) begin
                    d.st  = S_TA1;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_TA1: begin
                d.ta_hi = mdio_i;
                d.st    = S_TA2;
            end
            S_TA2: begin
                if (!q.is_rd && !(q.ta_hi && !mdio_i)) begin
                    abort = 1'b1;
                end else begin
                    d.st  = S_DAT;
                    d.cnt = '0;
                end
            end
            S_DAT: begin
                d.sh = wdata[DATA_W-2:0];
                if (q.cnt == DATA_LAST) begin
                    we    = !q.is_rd;
                    d.st  = S_PRE;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: abort = 1'b1;
        endcase
        if (abort) begin
            d.st  = S_PRE;
            d.cnt = '0;
        end
    end

    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign st       = q.st;
    assign cnt      = q.cnt;
    assign is_rd    = q.is_rd;
    assign reg_addr = q.ra;

endmodule

// File: rtl/mdio_regbank.sv
module mdio_regbank
    import mdio_resp_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int NREG = 1 << AW;

    logic [DW-1:0] mem_q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [DW-1:0] nxt_d;
        always_comb begin
            nxt_d = mem_q[i];
            if (we && addr == AW'(i)) nxt_d = wdata;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= nxt_d;
        end
    end

    assign rdata = mem_q[addr];

endmodule

// File: rtl/mdio_tx_drv.sv
module mdio_tx_drv
    import mdio_resp_pkg::*;
(
    input  logic              mdc,
    input  logic              rst_n,
    input  rx_state_e         st,
    input  logic              is_rd,
    input  logic [IDX_W-1:0]  bit_cnt,
    input  logic [DATA_W-1:0] rdata,
    output logic              mdio_o,
    output logic              mdio_oe
);

    tx_regs_t         q, d;
    logic [IDX_W-1:0] sel;

    always_comb begin
        sel  = IDX_W'(DATA_W - 1) - bit_cnt;
        d.oe = 1'b0;
        d.o  = 1'b1;
        if (is_rd && st == S_TA2) begin
            d.oe = 1'b1;
            d.o  = 1'b0;
        end else if (is_rd && st == S_DAT) begin
            d.oe = 1'b1;
            d.o  = rdata[sel];
        end
    end

    always_ff @(negedge mdc or negedge rst_n) begin
        if (!rst_n) q <= '{oe: 1'b0, o: 1'b1};
        else        q <= d;
    end

    assign mdio_o  = q.o;
    assign mdio_oe = q.oe;

endmodule

// File: rtl/mdio_responder.sv
module mdio_responder
    import mdio_resp_pkg::*;
#(
    parameter int PRE_LEN = PRE_LEN_DEF
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe
);

    rx_state_e         rx_st;
    logic [CNT_W-1:0]  rx_cnt;
    logic              rx_is_rd;
    logic [ADDR_W-1:0] rx_ra;
    logic              rx_we;
    logic [DATA_W-1:0] rx_wdata;
    logic [DATA_W-1:0] bank_rdata;

    mdio_rx_fsm #(.PRE_LEN(PRE_LEN)) u_rx (
        .mdc      (mdc),
        .rst_n    (rst_n),
        .mdio_i   (mdio_i),
        .phy_cfg  (phy_addr),
        .st       (rx_st),
        .cnt      (rx_cnt),
        .is_rd    (rx_is_rd),
        .reg_addr (rx_ra),
        .we       (rx_we),
        .wdata    (rx_wdata)
    );

    mdio_regbank u_bank (
        .clk   (mdc),
        .rst_n (rst_n),
        .we    (rx_we),
        .addr  (rx_ra),
        .wdata (rx_wdata),
        .rdata (bank_rdata)
    );

    mdio_tx_drv u_tx (
        .mdc     (mdc),
        .rst_n   (rst_n),
        .st      (rx_st),
        .is_rd   (rx_is_rd),
        .bit_cnt (rx_cnt[IDX_W-1:0]),
        .rdata   (bank_rdata),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

endmodule

// File: rtl/mdio_responder_chk.sv
module mdio_responder_chk
    import mdio_resp_pkg::*;
#(
    parameter int PRE_LEN = PRE_LEN_DEF
) (
    input logic             mdc,
    input logic             rst_n,
    input logic             mdio_o,
    input logic             mdio_oe,
    input rx_state_e        st,
    input logic [CNT_W-1:0] cnt,
    input logic             is_rd,
    input logic             we
);

    localparam logic [CNT_W-1:0] PRE_MAX   = CNT_W'(PRE_LEN);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    // R2
    pre_gate_chk: assert property (@(posedge mdc) disable iff (!rst_n)
        (st == S_PRE && cnt != PRE_MAX) |=> st == S_PRE);

    // R6
    ta1_release_chk: assert property (@(posedge mdc) disable iff (!rst_n)
        (st == S_TA1) |-> !mdio_oe);

    // R6
    ta2_zero_chk: assert property (@(posedge mdc) disable iff (!rst_n)
        (st == S_TA2 && is_rd) |-> (mdio_oe && !mdio_o));

    // R7
    oe_scope_chk: assert property (@(posedge mdc) disable iff (!rst_n)
        mdio_oe |-> (is_rd && (st == S_TA2 || st == S_DAT)));

    // R8
    write_slot_chk: assert property (@(posedge mdc) disable iff (!rst_n)
        we |-> (st == S_DAT && !is_rd && cnt == DATA_LAST));

    // R10
    rearm_chk: assert property (@(posedge mdc) disable iff (!rst_n)
        (st == S_DAT && cnt == DATA_LAST) |=> (st == S_PRE && cnt == '0));

endmodule

bind mdio_responder mdio_responder_chk #(.PRE_LEN(PRE_LEN)) u_chk (
    .mdc     (mdc),
    .rst_n   (rst_n),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .st      (rx_st),
    .cnt     (rx_cnt),
    .is_rd   (rx_is_rd),
    .we      (rx_we)
);

// File: tb/sim_mdio_responder.sv
module sim_mdio_responder;

    localparam int MDC_PERIOD = 20;
    localparam int WDOG_CYC   = 150000;

    typedef struct {
        string       tag;
        logic [17:0] oe;
        logic [17:0] o;
    } item_t;

    logic       mdc = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_bit = 1'b0;
    logic [4:0] cfg = 5'h0B;
    logic       mdio_o, mdio_oe;
    logic       line;

    int n_chk  = 0;
    int n_fail = 0;

    item_t exp_q[$];
    item_t obs_q[$];
    item_t obs2_q[$];

    assign line = mdio_oe ? mdio_o : host_bit;

    always #(MDC_PERIOD/2) mdc = ~mdc;

    mdio_responder u0 (
        .mdc      (mdc),
        .rst_n    (rst_n),
        .phy_addr (cfg),
        .mdio_i   (line),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // one bit period: drive after the falling edge, sample before and after the rising edge
    task automatic bit_io(input logic v, output logic oe_a, output logic o_a,
                          output logic oe_b, output logic o_b);
        @(negedge mdc);
        #1 host_bit = v;
        #(MDC_PERIOD/4);
        oe_a = mdio_oe;
        o_a  = mdio_o;
        #(MDC_PERIOD/2);
        oe_b = mdio_oe;
        o_b  = mdio_o;
    endtask

    task automatic frame(input int pre, input logic [1:0] stb, input logic [1:0] op,
                         input logic [4:0] pa, input logic [4:0] ra,
                         input logic [1:0] ta, input logic [15:0] dat,
                         input string tag, input logic drive, input logic [15:0] exp_d);
        item_t e, ob, ob2;
        logic  a, b, c, f;
        logic [13:0] head;
        logic [17:0] tail;
        head = {stb, op, pa, ra};
        tail = (op == 2'b10) ? 18'h3FFFF : {ta, dat};
        e.tag = tag;
        e.oe  = drive ? 18'b01_1111_1111_1111_1111 : 18'h0;
        e.o   = {2'b10, exp_d};
        exp_q.push_back(e);
        for (int i = 0; i < pre; i++) bit_io(1'b1, a, b, c, f);
        for (int i = 13; i >= 0; i--) bit_io(head[i], a, b, c, f);
        ob.tag = tag;
        ob2.tag = tag;
        for (int i = 17; i >= 0; i--) begin
            bit_io(tail[i], a, b, c, f);
            ob.oe[i]  = a;
            ob.o[i]   = b;
            ob2.oe[i] = c;
            ob2.o[i]  = f;
        end
        bit_io(1'b0, a, b, c, f);
        obs2_q.push_back(ob2);
        obs_q.push_back(ob);
    endtask

    task automatic wr(input int pre, input logic [1:0] stb, input logic [1:0] op,
                      input logic [4:0] pa, input logic [4:0] ra, input logic [1:0] ta,
                      input logic [15:0] dat, input string tag);
        frame(pre, stb, op, pa, ra, ta, dat, tag, 1'b0, 16'h0);
    endtask

    task automatic rd(input int pre, input logic [1:0] stb, input logic [4:0] pa,
                      input logic [4:0] ra, input string tag, input logic drive,
                      input logic [15:0] exp_d);
        frame(pre, stb, 2'b10, pa, ra, 2'b11, 16'hFFFF, tag, drive, exp_d);
    endtask

    // monitor: compares each observed bit sequence with the expected item
    initial begin
        forever begin
            item_t e, ob, ob2;
            wait (obs_q.size() > 0);
            e   = exp_q.pop_front();
            ob  = obs_q.pop_front();
            ob2 = obs2_q.pop_front();
            n_chk++;
            if (ob.oe !== e.oe || ((ob.o ^ e.o) & e.oe) !== 18'h0) begin
                n_fail++;
                $display("FAIL %s: oe=%b o=%b expected oe=%b o=%b",
                         e.tag, ob.oe, ob.o, e.oe, e.o);
            end
            // R9: output must not move at the rising edge inside each bit
            n_chk++;
            if (ob2.oe !== ob.oe || ((ob2.o ^ ob.o) & ob.oe) !== 18'h0) begin
                n_fail++;
                $display("FAIL R9 %s: after rising edge oe=%b o=%b expected oe=%b o=%b",
                         e.tag, ob2.oe, ob2.o, ob.oe, ob.o);
            end
        end
    end

    initial begin
        #(MDC_PERIOD * WDOG_CYC);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
    end

    initial begin
        #(MDC_PERIOD * 3 + 3);
        rst_n = 1'b1;
        @(negedge mdc);
        #(MDC_PERIOD/4);
        n_chk++;
        if (mdio_oe !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: mdio_oe=%b expected 0 after reset", mdio_oe);
        end

        // R1: untouched register reads zero
        rd(32, 2'b01, 5'h0B, 5'h09, "R1 reset value", 1'b1, 16'h0000);
        // R8, R6, R7: write then read back
        wr(32, 2'b01, 2'b00, 5'h0B, 5'h05, 2'b10, 16'hA5C3, "R8 write");
        rd(32, 2'b01, 5'h0B, 5'h05, "R7 R6 readback", 1'b1, 16'hA5C3);
        // R5: address and data bit order
        wr(32, 2'b01, 2'b00, 5'h0B, 5'h01, 2'b10, 16'h0001, "R5 write 01");
        wr(32, 2'b01, 2'b00, 5'h0B, 5'h10, 2'b10, 16'h8000, "R5 write 10");
        rd(32, 2'b01, 5'h0B, 5'h01, "R5 read 01", 1'b1, 16'h0001);
        rd(32, 2'b01, 5'h0B, 5'h10, "R5 read 10", 1'b1, 16'h8000);
        wr(32, 2'b01, 2'b00, 5'h0B, 5'h1F, 2'b10, 16'hC0DE, "R7 write 1F");
        rd(32, 2'b01, 5'h0B, 5'h1F, "R7 read 1F", 1'b1, 16'hC0DE);
        // R2: short and long runs of ones
        wr(31, 2'b01, 2'b00, 5'h0B, 5'h06, 2'b10, 16'h1234, "R2 short write");
        rd(32, 2'b01, 5'h0B, 5'h06, "R2 short write ignored", 1'b1, 16'h0000);
        rd(31, 2'b01, 5'h0B, 5'h05, "R2 short read", 1'b0, 16'h0);
        rd(40, 2'b01, 5'h0B, 5'h05, "R2 long run", 1'b1, 16'hA5C3);
        // R3: bad delimiter
        wr(32, 2'b00, 2'b00, 5'h0B, 5'h07, 2'b10, 16'h7777, "R3 bad start write");
        rd(32, 2'b00, 5'h0B, 5'h05, "R3 bad start read", 1'b0, 16'h0);
        rd(32, 2'b01, 5'h0B, 5'h07, "R3 register unchanged", 1'b1, 16'h0000);
        // R4: bad operation codes
        wr(32, 2'b01, 2'b01, 5'h0B, 5'h08, 2'b10, 16'h5555, "R4 op 01");
        wr(32, 2'b01, 2'b11, 5'h0B, 5'h08, 2'b10, 16'hAAAA, "R4 op 11");
        rd(32, 2'b01, 5'h0B, 5'h08, "R4 register unchanged", 1'b1, 16'h0000);
        // R5: foreign station address
        rd(32, 2'b01, 5'h0A, 5'h05, "R5 foreign read", 1'b0, 16'h0);
        wr(32, 2'b01, 2'b00, 5'h1B, 5'h05, 2'b10, 16'hFFFF, "R5 foreign write");
        rd(32, 2'b01, 5'h0B, 5'h05, "R5 register unchanged", 1'b1, 16'hA5C3);
        // R8: bad write turnaround
        wr(32, 2'b01, 2'b00, 5'h0B, 5'h0C, 2'b00, 16'hBEEF, "R8 ta 00");
        wr(32, 2'b01, 2'b00, 5'h0B, 5'h0C, 2'b11, 16'hBEEF, "R8 ta 11");
        rd(32, 2'b01, 5'h0B, 5'h0C, "R8 register unchanged", 1'b1, 16'h0000);
        // R10: no fresh run of ones after a completed and after a dropped frame
        rd(0, 2'b01, 5'h0B, 5'h05, "R10 after completed", 1'b0, 16'h0);
        rd(32, 2'b01, 5'h0A, 5'h05, "R10 setup dropped", 1'b0, 16'h0);
        rd(0, 2'b01, 5'h0B, 5'h05, "R10 after dropped", 1'b0, 16'h0);
        rd(32, 2'b01, 5'h0B, 5'h05, "R10 rearmed", 1'b1, 16'hA5C3);

        wait (obs_q.size() == 0);
        #1;
        summary();
    end

endmodule